// File: doc/BRIEF.md
# Two-Rate Integrating Converter Sequencer

This block sequences the digital side of an integrating analog-to-digital converter. On a start pulse it closes the input switch for a run-up window. The width of that window is chosen by a resolution select. It then samples the sign of the integrated signal and discharges the integrator in two stages. The first stage uses a fast reference of the opposite polarity. When the near-zero comparator fires, the fast reference is removed and a slow reference takes over until the zero crossing. Only one switch is ever closed at a time, and a one-clock gap with every switch open separates any two switch closures.

The result is the fast-stage cycle count times a fixed ratio, plus the slow-stage cycle count. It is offered on a valid/ready output together with a polarity bit and an overrange flag. Once `res_valid` rises, the magnitude, the polarity and the flag stay frozen until a cycle in which `res_ready` is high. The block then returns to idle on the next clock. Back-pressure simply holds the result. Start requests are accepted only in idle, so a new conversion cannot begin while a result is waiting. The analog integrator, the comparators and the references sit outside the block.

Top module: `tworate_adc_seq`

## Requirements
- R1: After reset all three switch controls are low, `res_valid` is low and `overrange` is low.
- R2: A start seen in idle raises `sw_input` on the next clock. It stays high for exactly BASE_SAMPLES << `res_sel` cycles (4, 8, 16 or 32 with the defaults).
- R3: At most one of `sw_input`, `sw_fast` and `sw_slow` is high in any cycle. A switch never closes in the cycle right after another switch was high.
- R4: `pos_in` is sampled in the last run-up cycle. During both discharge stages `ref_neg` equals that sample (1 selects the negative reference). With the result, `res_neg` is its inverse.
- R5: `sw_fast` stays high up to and including the first cycle in which `near_zero` is high. After one gap cycle, `sw_slow` rises.
- R6: `sw_slow` stays high up to and including the first cycle in which `zero_cross` is high. The result is then valid with `magnitude` = F*RATIO + S, where F and S are the numbers of cycles the fast and slow switches were high.
- R7: If either discharge stage reaches TIMEOUT cycles without its flag, the conversion ends with `overrange` = 1 and `magnitude` all ones. A flag that arrives in the TIMEOUT-th cycle itself still counts as a normal end.
- R8: `high_det` high during a run-up cycle aborts the conversion at once. No discharge stage follows, and the result carries `overrange` = 1 and `magnitude` all ones.
- R9: While `res_valid` is high and `res_ready` is low, the result stays unchanged. A cycle with `res_ready` high drops `res_valid` on the next clock. Start is ignored outside idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a conversion (accepted in idle only) |
| res_sel | input | 2 | Resolution select, run-up of BASE_SAMPLES << res_sel cycles |
| pos_in | input | 1 | Sign comparator, 1 when the integrated input is positive |
| high_det | input | 1 | Integrator high-level detect |
| near_zero | input | 1 | Integrator near-zero detect |
| zero_cross | input | 1 | Integrator zero-crossing detect |
| sw_input | output | 1 | Close the unknown-input switch |
| sw_fast | output | 1 | Close the fast-discharge reference switch |
| sw_slow | output | 1 | Close the slow-discharge reference switch |
| ref_neg | output | 1 | Reference polarity, 1 selects negative |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Result accepted |
| magnitude | output | 12 | Weighted count, all ones on overrange |
| res_neg | output | 1 | Result polarity, 1 for a negative input |
| overrange | output | 1 | Conversion ended by timeout or high-level detect |

## Verification
A discharge stage can end in the same cycle for two reasons: its flag arrives, and its timeout counter reaches TIMEOUT. The bench provokes this by placing `near_zero` or `zero_cross` exactly in the TIMEOUT-th cycle of the stage. It then expects a normal result whose count includes that cycle. It places the flag one cycle later to expect overrange with all-ones magnitude. The same clash between a held result and a new start is provoked by keeping `start` high across the whole conversion and the back-pressure wait. The bench judges it by counting run-up windows, and exactly one is expected.

// File: rtl/tr_pkg.sv
package tr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RUNUP,
    ST_GAP1,
    ST_FAST,
    ST_GAP2,
    ST_SLOW,
    ST_HOLD
  } tr_state_t;
endpackage

// File: rtl/tr_sample_time.sv
module tr_sample_time #(
  parameter int BASE_SAMPLES = 4,
  parameter int RES_W        = 2,
  parameter int CNT_W        = 8
) (
  input  logic [RES_W-1:0] res_sel,
  output logic [CNT_W-1:0] t_len
);
  // Each resolution step doubles the run-up window.
  always_comb t_len = CNT_W'(BASE_SAMPLES) << res_sel;
endmodule

// File: rtl/tr_phase_fsm.sv
module tr_phase_fsm
  import tr_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int TIMEOUT = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] t_len,
  input  logic             pos_in,
  input  logic             high_det,
  input  logic             near_zero,
  input  logic             zero_cross,
  input  logic             res_ready,
  output tr_state_t        state,
  output logic             sign_pos,
  output logic             ovr,
  output logic             clr,
  output logic             inc_fast,
  output logic             inc_slow
);
  localparam logic [CNT_W-1:0] TMO_LAST = CNT_W'(TIMEOUT - 1);

  logic [CNT_W-1:0] cnt;

  always_comb begin
    clr      = (state == ST_IDLE) && start;
    inc_fast = (state == ST_FAST);
    inc_slow = (state == ST_SLOW);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      sign_pos <= 1'b0;
      ovr      <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          state <= ST_RUNUP;
          cnt   <= '0;
          ovr   <= 1'b0;
        end
        ST_RUNUP: begin
          if (high_det) begin
            ovr   <= 1'b1;
            state <= ST_HOLD;
          end else if (cnt == t_len - CNT_W'(1)) begin
            sign_pos <= pos_in;
            state    <= ST_GAP1;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_GAP1: begin
          state <= ST_FAST;
          cnt   <= '0;
        end
        ST_FAST: begin
          if (near_zero) begin
            state <= ST_GAP2;
          end else if (cnt == TMO_LAST) begin
            ovr   <= 1'b1;
            state <= ST_HOLD;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_GAP2: begin
          state <= ST_SLOW;
          cnt   <= '0;
        end
        ST_SLOW: begin
          if (zero_cross) begin
            state <= ST_HOLD;
          end else if (cnt == TMO_LAST) begin
            ovr   <= 1'b1;
            state <= ST_HOLD;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_HOLD: if (res_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tr_accum.sv
module tr_accum #(
  parameter int TIMEOUT = 12,
  parameter int RATIO   = 8,
  parameter int MAG_W   = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc_fast,
  input  logic             inc_slow,
  input  logic             ovr,
  output logic [MAG_W-1:0] magnitude
);
  localparam int PH_W  = $clog2(TIMEOUT + 1);
  localparam int SUM_W = PH_W + $clog2(RATIO + 1) + 1;
  localparam int W     = (SUM_W > MAG_W ? SUM_W : MAG_W) + 1;
  localparam logic [W-1:0] MAG_MAX = W'({MAG_W{1'b1}});

  logic [PH_W-1:0] fast_n, slow_n;
  logic [W-1:0]    sum;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fast_n <= '0;
      slow_n <= '0;
    end else if (clr) begin
      fast_n <= '0;
      slow_n <= '0;
    end else begin
      if (inc_fast) fast_n <= fast_n + PH_W'(1);
      if (inc_slow) slow_n <= slow_n + PH_W'(1);
    end
  end

  always_comb begin
    sum = W'(fast_n) * W'(RATIO) + W'(slow_n);
    if (ovr || sum > MAG_MAX) magnitude = '1;
    else                      magnitude = sum[MAG_W-1:0];
  end
endmodule

// File: rtl/tworate_adc_seq.sv
module tworate_adc_seq
  import tr_pkg::*;
#(
  parameter int BASE_SAMPLES = 4,
  parameter int RES_W        = 2,
  parameter int RATIO        = 8,
  parameter int TIMEOUT      = 12,
  parameter int MAG_W        = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [RES_W-1:0] res_sel,
  input  logic             pos_in,
  input  logic             high_det,
  input  logic             near_zero,
  input  logic             zero_cross,
  output logic             sw_input,
  output logic             sw_fast,
  output logic             sw_slow,
  output logic             ref_neg,
  output logic             res_valid,
  input  logic             res_ready,
  output logic [MAG_W-1:0] magnitude,
  output logic             res_neg,
  output logic             overrange
);
  localparam int T_MAX = BASE_SAMPLES << ((1 << RES_W) - 1);
  localparam int C_MAX = (T_MAX > TIMEOUT) ? T_MAX : TIMEOUT;
  localparam int CNT_W = $clog2(C_MAX + 1) + 1;

  tr_state_t        state;
  logic [CNT_W-1:0] t_len;
  logic             sign_pos, ovr, clr, inc_fast, inc_slow;

  tr_sample_time #(.BASE_SAMPLES(BASE_SAMPLES), .RES_W(RES_W), .CNT_W(CNT_W)) u_time (
    .res_sel (res_sel),
    .t_len   (t_len)
  );

  tr_phase_fsm #(.CNT_W(CNT_W), .TIMEOUT(TIMEOUT)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .t_len      (t_len),
    .pos_in     (pos_in),
    .high_det   (high_det),
    .near_zero  (near_zero),
    .zero_cross (zero_cross),
    .res_ready  (res_ready),
    .state      (state),
    .sign_pos   (sign_pos),
    .ovr        (ovr),
    .clr        (clr),
    .inc_fast   (inc_fast),
    .inc_slow   (inc_slow)
  );

  tr_accum #(.TIMEOUT(TIMEOUT), .RATIO(RATIO), .MAG_W(MAG_W)) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .inc_fast  (inc_fast),
    .inc_slow  (inc_slow),
    .ovr       (ovr),
    .magnitude (magnitude)
  );

  // Switches decode straight from the state register; gap states open all.
  always_comb begin
    sw_input  = (state == ST_RUNUP);
    sw_fast   = (state == ST_FAST);
    sw_slow   = (state == ST_SLOW);
    ref_neg   = sign_pos;
    res_valid = (state == ST_HOLD);
    res_neg   = ~sign_pos;
    overrange = ovr;
  end
endmodule

// File: rtl/tr_seq_checker.sv
module tr_seq_checker #(
  parameter int MAG_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             sw_input,
  input logic             sw_fast,
  input logic             sw_slow,
  input logic             ref_neg,
  input logic             res_valid,
  input logic             res_ready,
  input logic [MAG_W-1:0] magnitude,
  input logic             res_neg,
  input logic             overrange
);
  a_r3_one_switch: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sw_input, sw_fast, sw_slow}));

  a_r3_gap_fast: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_fast) |-> $past(!sw_input && !sw_slow));

  a_r3_gap_slow: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_slow) |-> $past(!sw_input && !sw_fast));

  a_r4_ref_steady: assert property (@(posedge clk) disable iff (!rst_n)
    ((sw_fast || sw_slow) && $past(sw_fast || sw_slow)) |-> $stable(ref_neg));

  a_r9_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=>
      (res_valid && $stable(magnitude) && $stable(res_neg) && $stable(overrange)));

  a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_ready) |=> !res_valid);

  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && start) |=> !sw_input);

  a_r6_open_when_valid: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !(sw_input || sw_fast || sw_slow));
endmodule

bind tworate_adc_seq tr_seq_checker #(.MAG_W(MAG_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .sw_input  (sw_input),
  .sw_fast   (sw_fast),
  .sw_slow   (sw_slow),
  .ref_neg   (ref_neg),
  .res_valid (res_valid),
  .res_ready (res_ready),
  .magnitude (magnitude),
  .res_neg   (res_neg),
  .overrange (overrange)
);

// File: tb/tworate_adc_seq_bench.sv
module tworate_adc_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int BASE = 4;
  localparam int RATIO = 8;
  localparam int TMO = 12;
  localparam int MAG_W = 12;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, res_ready = 1'b0;
  logic [1:0] res_sel = '0;
  logic pos_in = 1'b0;
  logic high_det, near_zero, zero_cross;
  logic sw_input, sw_fast, sw_slow, ref_neg, res_valid, res_neg, overrange;
  logic [MAG_W-1:0] magnitude;

  int n_tests = 0, n_fail = 0;
  int cfg_f = 1, cfg_s = 1, cfg_h = 0;
  logic clr_cnt = 1'b0;
  int iseen, fseen, sseen, rises, ref_bad;
  logic prev_in;

  tworate_adc_seq u_tworate_adc_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .res_sel(res_sel), .pos_in(pos_in),
    .high_det(high_det), .near_zero(near_zero), .zero_cross(zero_cross),
    .sw_input(sw_input), .sw_fast(sw_fast), .sw_slow(sw_slow), .ref_neg(ref_neg),
    .res_valid(res_valid), .res_ready(res_ready), .magnitude(magnitude),
    .res_neg(res_neg), .overrange(overrange)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural integrator: flags fire on a chosen cycle of each phase.
  assign high_det   = sw_input && (cfg_h != 0) && (iseen == cfg_h - 1);
  assign near_zero  = sw_fast && (fseen == cfg_f - 1);
  assign zero_cross = sw_slow && (sseen == cfg_s - 1);

  always @(posedge clk) begin
    if (clr_cnt) begin
      iseen <= 0; fseen <= 0; sseen <= 0; rises <= 0; ref_bad <= 0; prev_in <= 1'b0;
    end else begin
      if (sw_input) iseen <= iseen + 1;
      if (sw_fast)  fseen <= fseen + 1;
      if (sw_slow)  sseen <= sseen + 1;
      prev_in <= sw_input;
      if (sw_input && !prev_in) rises <= rises + 1;
      if ((sw_fast || sw_slow) && ref_neg != pos_in) ref_bad <= ref_bad + 1;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One conversion; returns after the handshake.
  task automatic run(input int rs, input bit pos, input int f, input int s,
                     input int h, input int delay, input bit hold_start);
    int exp_mag, exp_i, exp_f, exp_s;
    bit exp_ovr;
    logic [MAG_W-1:0] snap;
    @(negedge clk);
    res_sel = 2'(rs); pos_in = pos; cfg_f = f; cfg_s = s; cfg_h = h;
    clr_cnt = 1'b1;
    @(negedge clk);
    clr_cnt = 1'b0; start = 1'b1;
    @(negedge clk);
    if (!hold_start) start = 1'b0;
    check("R2 input switch after start", int'(sw_input), 1);
    for (int k = 0; k < 400; k++) begin
      if (res_valid) break;
      @(negedge clk);
    end
    exp_i = BASE << rs;
    exp_f = 0; exp_s = 0; exp_ovr = 1'b0;
    if (h != 0 && h <= exp_i) begin
      exp_i = h; exp_ovr = 1'b1;                                  // R8
    end else if (f > TMO) begin
      exp_f = TMO; exp_ovr = 1'b1;                                // R7
    end else if (s > TMO) begin
      exp_f = f; exp_s = TMO; exp_ovr = 1'b1;                     // R7
    end else begin
      exp_f = f; exp_s = s;
    end
    exp_mag = exp_ovr ? (1 << MAG_W) - 1 : exp_f * RATIO + exp_s; // R6
    check("R6 result valid", int'(res_valid), 1);
    check("R2 run-up width", iseen, exp_i);
    check("R5 fast cycles", fseen, exp_f);
    check("R6 slow cycles", sseen, exp_s);
    check("R6/R7 magnitude", int'(magnitude), exp_mag);
    check("R7/R8 overrange", int'(overrange), int'(exp_ovr));
    if (!exp_ovr) begin
      check("R4 polarity", int'(res_neg), int'(!pos));
      check("R4 reference sign", ref_bad, 0);
    end
    snap = magnitude;
    for (int k = 0; k < delay; k++) begin
      @(negedge clk);
      check("R9 held valid", int'(res_valid), 1);
      check("R9 held magnitude", int'(magnitude), int'(snap));
    end
    if (hold_start) start = 1'b0;
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    check("R9 valid drops after accept", int'(res_valid), 0);
    check("R9 single run-up", rises, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 3);
    @(negedge clk);
    check("R1 reset switches", int'({sw_input, sw_fast, sw_slow}), 0);
    check("R1 reset valid", int'(res_valid), 0);
    check("R1 reset overrange", int'(overrange), 0);
    rst_n = 1'b1;
    // R2 R4 R5 R6: sweep resolution, sign, fast and slow counts
    for (int rs = 0; rs < 4; rs++)
      for (int p = 0; p < 2; p++)
        for (int f = 1; f <= 4; f++)
          for (int s = 1; s <= 4; s++)
            run(rs, p[0], f, s, 0, 0, 1'b0);
    // R7 boundaries: flag on the last allowed cycle vs one later
    run(0, 1'b1, TMO, 3, 0, 0, 1'b0);
    run(0, 1'b1, TMO + 1, 3, 0, 0, 1'b0);
    run(1, 1'b0, 2, TMO, 0, 0, 1'b0);
    run(1, 1'b0, 2, TMO + 1, 0, 0, 1'b0);
    run(0, 1'b1, TMO, TMO, 0, 0, 1'b0);
    // R8 high-level detect during run-up
    run(2, 1'b1, 2, 2, 3, 0, 1'b0);
    run(0, 1'b0, 2, 2, 1, 0, 1'b0);
    run(0, 1'b0, 2, 2, 4, 0, 1'b0);
    // R9 back-pressure and start held across the whole conversion
    run(1, 1'b1, 3, 2, 0, 5, 1'b0);
    run(0, 1'b0, 4, 4, 0, 3, 1'b1);
    run(3, 1'b1, 1, 1, 0, 2, 1'b1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule